// File: doc/BRIEF.md
# Coprocessor Multiply-Divide-Accumulate Unit

This block is a 16-bit arithmetic coprocessor that sits beside a small processor. The processor first writes a 7-bit mode word. The low nibble of that word picks the operation, and the upper three bits pick which half of the 32-bit result appears on the 16-bit output port. Each issue strobe then presents two 16-bit operands. The chosen operation writes its outcome into a single shared 32-bit results register.

The operations cover the following:
- clearing the results register;
- preloading it from one operand or from both;
- reading it back unchanged;
- unsigned and signed multiplication;
- signed multiply-accumulate into the results register;
- unsigned and signed division, with the quotient in the lower half and the remainder in the upper half.

Every operation completes in the clock edge where it is issued. The processor reads a 32-bit result in two halves by rewriting the output-select field between the two reads.

Top module: `cop_muldiv`

## Requirements
- R1: A 7-bit mode register loads `mode_in` on any cycle with `mode_we` high and resets to 0. Bits [3:0] hold the operation code and bits [6:4] hold the output select. An issue in the same cycle as a mode write executes with the mode held before that write.
- R2: `res_out` shows the upper 16 bits of the results register when the output select is 1. For every other select value (0 and 2..7) it shows the lower 16 bits. It follows the register combinationally.
- R3: Operation 0x0 sets the results register to zero and clears the divide-error flag.
- R4: Operation 0x1 loads `op_b` into bits [15:0] of the results register and zeros bits [31:16].
- R5: Operation 0x2 loads {`op_a`, `op_b`} into the results register, with `op_a` in bits [31:16].
- R6: Operation 0x3 leaves the results register unchanged.
- R7: Operation 0x4 stores the unsigned 32-bit product of `op_a` and `op_b`. Operation 0x5 stores the signed (two's complement) 32-bit product.
- R8: Operation 0x7 adds the signed product of `op_a` and `op_b` to the results register, modulo 2^32.
- R9: Operation 0x8 divides `op_a` by `op_b` unsigned. The quotient goes to bits [15:0] and the remainder to bits [31:16].
- R10: Operation 0x9 divides signed. The quotient truncates toward zero, the remainder carries the sign of the dividend, and both are kept to their low 16 bits. For example, 0x8000 / 0xFFFF gives quotient 0x8000 and remainder 0.
- R11: A division (0x8 or 0x9) with `op_b` = 0 writes 0xFFFFFFFF and sets `div_err`. The flag stays set until reset or an issued operation 0x0.
- R12: An issue with a reserved operation code (0x6 or 0xA..0xF) leaves the results register and `div_err` unchanged. Without an issue, the results register never changes.
- R13: Reset clears the results register and `div_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_in | input | 7 | Mode word: [6:4] output select, [3:0] operation |
| issue | input | 1 | Operation issue strobe |
| op_a | input | 16 | Operand A (multiplicand, dividend, upper preload half) |
| op_b | input | 16 | Operand B (multiplier, divisor, lower preload half) |
| res_out | output | 16 | Selected half of the results register |
| div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The assertions assume that the strobes and operands never carry unknown values on a clock edge. They also assume that the operands are meaningful only in the cycle where `issue` is high.

The stimulus drives every input on the falling edge. It holds each strobe for exactly one cycle and always gives a defined value to both operands.

Division by zero is a defined case rather than an excluded one. The stimulus therefore includes a zero divisor in every division sweep, and it checks the sticky flag across later operations as well as across a clear.

// File: rtl/cop_muldiv.sv
module cop_muldiv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_we,
  input  logic [6:0]   mode_in,
  input  logic         issue,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] res_out,
  output logic         div_err
);
  localparam int RW = 2 * W;

  logic [6:0]    mode_q;
  logic [RW-1:0] acc_q, acc_d;
  logic          err_d;

  wire [3:0] opc = mode_q[3:0];
  wire       hi_sel = (mode_q[6:4] == 3'd1);
  wire       bz = (op_b == '0);

  wire [RW-1:0] ua = {{W{1'b0}}, op_a};
  wire [RW-1:0] ub = {{W{1'b0}}, op_b};
  wire [RW-1:0] sa = {{W{op_a[W-1]}}, op_a};
  wire [RW-1:0] sb = {{W{op_b[W-1]}}, op_b};
  wire [RW-1:0] uprod = ua * ub;
  wire [RW-1:0] sprod = sa * sb;

  wire [RW-1:0] ud = bz ? RW'(1) : ub;
  wire [RW-1:0] sd = bz ? RW'(1) : sb;
  wire [RW-1:0] uq = ua / ud;
  wire [RW-1:0] ur = ua % ud;
  wire signed [RW-1:0] sq = $signed(sa) / $signed(sd);
  wire signed [RW-1:0] sr = $signed(sa) % $signed(sd);

  always_comb begin
    acc_d = acc_q;
    err_d = div_err;
    if (issue) begin
      case (opc)
        4'h0: begin acc_d = '0; err_d = 1'b0; end
        4'h1: acc_d = ub;
        4'h2: acc_d = {op_a, op_b};
        4'h4: acc_d = uprod;
        4'h5: acc_d = sprod;
        4'h7: acc_d = acc_q + sprod;
        4'h8: begin
          if (bz) begin acc_d = '1; err_d = 1'b1; end
          else acc_d = {ur[W-1:0], uq[W-1:0]};
        end
        4'h9: begin
          if (bz) begin acc_d = '1; err_d = 1'b1; end
          else acc_d = {sr[W-1:0], sq[W-1:0]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      acc_q   <= '0;
      div_err <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_in;
      acc_q   <= acc_d;
      div_err <= err_d;
    end
  end

  assign res_out = hi_sel ? acc_q[RW-1:W] : acc_q[W-1:0];

  assert_mode_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_q == $past(mode_in));
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_we |=> $stable(mode_q));
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue && opc == 4'h0 |=> acc_q == '0 && !div_err);
  assert_load16_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue && opc == 4'h1 |=> acc_q[RW-1:W] == '0 && acc_q[W-1:0] == $past(op_b));
  assert_load32_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && opc == 4'h2 |=> acc_q == {$past(op_a), $past(op_b)});
  assert_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue && opc == 4'h3 |=> $stable(acc_q));
  assert_divzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (opc == 4'h8 || opc == 4'h9) && bz |=> acc_q == '1 && div_err);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    div_err && !(issue && opc == 4'h0) |=> div_err);
  assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (opc == 4'h6 || opc >= 4'hA) |=> $stable(acc_q) && $stable(div_err));
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(acc_q) && $stable(div_err));
endmodule

// File: tb/tb_cop_muldiv.sv
module tb_cop_muldiv;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [6:0]  mode_in = '0;
  logic        issue = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [15:0] res_out;
  logic        div_err;

  int checks = 0;
  int fails = 0;
  logic [31:0] model = '0;
  logic        merr = 1'b0;

  cop_muldiv dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] vals [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h0007, 16'h7FFF, 16'h8000,
                             16'h8001, 16'hFFFF, 16'h1234, 16'hFFFE, 16'h00FF, 16'h012C};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [6:0] m);
    @(negedge clk); mode_we = 1'b1; mode_in = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic do_issue(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk); issue = 1'b1; op_a = a; op_b = b;
    @(negedge clk); issue = 1'b0; #1;
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic apply_model(input logic [3:0] opc, input logic [15:0] a, input logic [15:0] b);
    int sa, sb, q, r;
    longint up;
    sa = int'($signed(a)); sb = int'($signed(b));
    case (opc)
      4'h0: begin model = '0; merr = 1'b0; end
      4'h1: model = {16'h0, b};
      4'h2: model = {a, b};
      4'h4: begin up = longint'(a) * longint'(b); model = up[31:0]; end
      4'h5: model = 32'(sa * sb);
      4'h7: model = model + 32'(sa * sb);
      4'h8: if (b == 0) begin model = '1; merr = 1'b1; end
            else model = {16'(a % b), 16'(a / b)};
      4'h9: if (b == 0) begin model = '1; merr = 1'b1; end
            else begin q = sa / sb; r = sa - q * sb; model = {r[15:0], q[15:0]}; end
      default: ;
    endcase
  endtask

  task automatic run_op(input string req, input logic [3:0] opc, input logic [15:0] a, input logic [15:0] b);
    set_mode({3'd0, opc});
    do_issue(a, b);
    apply_model(opc, a, b);
    chk(req, {16'h0, res_out}, {16'h0, model[15:0]});
    set_mode({3'd1, opc});
    #1 chk(req, {16'h0, res_out}, {16'h0, model[31:16]});
    chk("R11", {31'h0, div_err}, {31'h0, merr});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R13", {15'h0, div_err, res_out}, 32'h0);
    rst_n = 1'b1;
    // R13 reset state observed in both halves
    set_mode(7'h10);
    #1 chk("R13", {16'h0, res_out}, 32'h0);

    // R5 and R2: preload and read both halves, plus a reserved select
    run_op("R5", 4'h2, 16'hABCD, 16'h1357);
    set_mode(7'h53);
    #1 chk("R2", {16'h0, res_out}, 32'h1357);
    set_mode(7'h73);
    #1 chk("R2", {16'h0, res_out}, 32'h1357);

    // R6 readback and R4 16-bit preload
    run_op("R6", 4'h3, 16'hFFFF, 16'hFFFF);
    run_op("R4", 4'h1, 16'h5555, 16'h8001);
    run_op("R3", 4'h0, 16'h1111, 16'h2222);

    // R7 / R9 / R10 sweeps over corner operand pairs
    foreach (vals[i]) foreach (vals[j]) begin
      run_op("R7", 4'h4, vals[i], vals[j]);
      run_op("R7", 4'h5, vals[i], vals[j]);
      run_op("R9", 4'h8, vals[i], vals[j]);
      run_op("R10", 4'h9, vals[i], vals[j]);
    end

    // R11 sticky flag survives other operations, cleared by clear
    run_op("R11", 4'h8, 16'h0009, 16'h0000);
    run_op("R11", 4'h4, 16'h0003, 16'h0003);
    run_op("R11", 4'h2, 16'h0001, 16'h0002);
    run_op("R3", 4'h0, 16'h0000, 16'h0000);

    // R8 multiply-accumulate chain from a preload
    run_op("R5", 4'h2, 16'h7FFF, 16'hFFF0);
    foreach (vals[i]) foreach (vals[j]) run_op("R8", 4'h7, vals[i], vals[j]);

    // R12 reserved codes leave the register and flag alone
    run_op("R11", 4'h9, 16'h8000, 16'h0000);
    run_op("R5", 4'h2, 16'hC0DE, 16'hBEEF);
    for (int k = 0; k < 16; k++) begin
      if (k == 6 || k >= 10) run_op("R12", 4'(k), 16'h0F0F, 16'h0003);
    end

    // R1 mode write and issue in the same cycle use the old mode
    set_mode(7'h04);
    @(negedge clk); mode_we = 1'b1; mode_in = 7'h10; issue = 1'b1; op_a = 16'd3; op_b = 16'd5;
    @(negedge clk); mode_we = 1'b0; issue = 1'b0; #1;
    chk("R1", {16'h0, res_out}, 32'h0);
    set_mode(7'h00);
    #1 chk("R1", {16'h0, res_out}, 32'd15);
    // R3 clear now clears the flag left by the divide above
    do_issue(16'h1, 16'h1);
    chk("R3", {15'h0, div_err, res_out}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule